// File: doc/BRIEF.md
# SPI Flash User-Command Transfer Engine

This block is a register-programmed SPI master for driving a serial flash under direct software control. Software loads up to 64 bytes into a word-addressed data buffer, programs the burst length in bits, and sets a start bit. The engine then asserts chip select and shifts the buffer out MSB first, one bit per pair of serial-clock strobes. The strobes come from a separate clock generator. When capture is enabled, the bit sampled on each rising strobe overwrites the buffer bit just sent, so the same buffer holds the received data once the burst ends.

Completion is signalled by a sticky done flag that software clears before each start. Chip select can be held low after a burst, which lets one flash command span several bursts. A software reset bit aborts a running burst. A control bit that enables memory-mapped reads is only stored and brought out, but while it is set, user bursts are refused.

Top module: `sfe_engine`

## Requirements
- R1: After reset, every register offset from 0x00 to 0x3C reads 0, `spiCsN` is 1, `spiSck` is 0, `spiMosi` is 0 and `mmioReadEn` is 0.
- R2: The words at 0x00 (command), 0x04 (address), 0x08 (control), 0x18 (clock), 0x1C (user), 0x20 (user1), 0x2C (user4) and 0x30 (slave) read back what was written, except for the self-acting bits named in R4, R8, R11 and R12. Other offsets below 0x40 read 0 and ignore writes. Control bit 17 drives `mmioReadEn`.
- R3: Offsets 0x40 to 0x7C hold the buffer as sixteen 32-bit words. Burst byte k is word k/4, bits 8*(k mod 4)+7 down to 8*(k mod 4).
- R4: Writing command bit 18 = 1 starts a burst only when all of these hold: the engine is idle, user bit 27 (data-out enable) is 1, slave bit 30 (mode) is 0, and control bit 17 is 0. Otherwise the write has no effect: chip select stays high and the done flag is not set.
- R5: User1 bits 25:17 hold the bit count minus one. A burst sends exactly that many plus one bits and may end in the middle of a byte.
- R6: Burst bit b is bit 7-(b mod 8) of byte b/8. The first bit is on `spiMosi` one cycle after the start write. `spiSck` goes high one cycle after a rising strobe and low one cycle after a falling strobe, and the next bit appears together with the low edge. Strobes have no effect while idle.
- R7: With user bit 0 = 1, `spiMiso` sampled at each rising strobe replaces the buffer bit just sent. With user bit 0 = 0, the buffer is left unchanged.
- R8: Slave bit 4 (done) becomes 1 exactly once per burst, two clock edges after the rising strobe of the last bit, when `spiSck` also returns low. Writing the slave word with bit 4 = 0 clears it. Writing bit 4 = 1 never sets it.
- R9: `spiCsN` goes low with the first bit. At the end of the burst it returns high if user4 bit 30 is 0 and stays low if it is 1.
- R10: A start write during a busy burst is ignored, so the burst ends after its programmed bit count.
- R11: Writing slave bit 31 = 1 aborts any burst at once. It drives `spiCsN` high and `spiSck` and `spiMosi` low and clears done. Bit 31 reads 0, and the other registers keep their values.
- R12: Command bit 18 reads 1 while a burst is in progress and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register or buffer write strobe |
| regAddr | input | 7 | Byte offset of the access |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for `regAddr`, combinational |
| sckRiseStb | input | 1 | Rising serial-clock edge strobe from the clock generator |
| sckFallStb | input | 1 | Falling serial-clock edge strobe from the clock generator |
| spiSck | output | 1 | Serial clock, idle low |
| spiCsN | output | 1 | Flash chip select, active low |
| spiMosi | output | 1 | Serial data out |
| spiMiso | input | 1 | Serial data in |
| mmioReadEn | output | 1 | Memory-mapped read enable from control bit 17 |

## Verification
Bursts run with a whole number of words, with a length that stops mid-byte (11 bits), with a single byte and with 16 bits. The aligned burst checks byte lane order, and the ragged one checks that counting is done in bits and not bytes. Capture runs with an irregular input pattern, so a misplaced bit index or lane shows up in the buffer readback, and a burst with capture off shows the buffer left intact. Back-to-back bursts with chip-select hold set and then cleared separate the hold from the release. Refused starts, a second start mid-burst, clearing of the done flag and an abort while the clock is high test the guard conditions.

// File: rtl/sfe_pkg.sv
package sfe_pkg;

  // Register word offsets (byte addresses); the buffer starts at BUF_BASE.
  localparam logic [7:0] OFF_CMD   = 8'h00;
  localparam logic [7:0] OFF_ADDR  = 8'h04;
  localparam logic [7:0] OFF_CTRL  = 8'h08;
  localparam logic [7:0] OFF_CLOCK = 8'h18;
  localparam logic [7:0] OFF_USER  = 8'h1C;
  localparam logic [7:0] OFF_USER1 = 8'h20;
  localparam logic [7:0] OFF_USER4 = 8'h2C;
  localparam logic [7:0] OFF_SLAVE = 8'h30;

  // Bit positions that carry behaviour.
  localparam int BIT_START   = 18; // command
  localparam int BIT_MMIO    = 17; // control
  localparam int BIT_RXCAP   = 0;  // user
  localparam int BIT_DOUT    = 27; // user
  localparam int BIT_LEN_LSB = 17; // user1
  localparam int BIT_HOLDCS  = 30; // user4
  localparam int BIT_DONE    = 4;  // slave
  localparam int BIT_MODE    = 30; // slave
  localparam int BIT_SRST    = 31; // slave

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT_RISE,
    ST_WAIT_FALL,
    ST_WRAP
  } sfeState_t;

  // Strobes from the control to the datapath.
  typedef struct packed {
    logic loadBit;   // present buffer bit at bitPos on MOSI
    logic sampleBit; // capture MISO into buffer bit at bitPos
    logic doneSet;   // burst finished
    logic abort;     // soft reset
  } sfeStrobe_t;

endpackage

// File: rtl/sfe_datapath.sv
module sfe_datapath
  import sfe_pkg::*;
#(
  parameter int BUF_BYTES = 64,
  localparam int ADDR_W  = $clog2(BUF_BYTES) + 1,
  localparam int POS_W   = $clog2(BUF_BYTES * 8),
  localparam int BYTE_W  = $clog2(BUF_BYTES),
  localparam int WIDX_W  = BYTE_W - 2,
  localparam int RWORD_W = ADDR_W - 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  logic              busy,
  input  sfeStrobe_t        strb,
  input  logic [POS_W-1:0]  bitPos,
  input  logic              spiMiso,
  output logic              spiMosi,
  output logic              startReq,
  output logic              softRst,
  output logic              holdCs,
  output logic [POS_W-1:0]  lastPos,
  output logic              doneFlag,
  output logic              mmioReadEn
);

  // Address decode: top address bit selects the buffer half.
  logic              isBuf;
  logic [RWORD_W-1:0] regWord;
  logic [WIDX_W-1:0] bufWord;
  logic [1:0]        unusedAddrLsb;

  assign isBuf         = regAddr[ADDR_W-1];
  assign regWord       = regAddr[ADDR_W-2:2];
  assign bufWord       = regAddr[2 +: WIDX_W];
  assign unusedAddrLsb = regAddr[1:0];

  function automatic logic hit(input logic [RWORD_W-1:0] w, input logic [7:0] off);
    return w == RWORD_W'(off >> 2);
  endfunction

  logic wrCmd, wrAddr, wrCtrl, wrClock, wrUser, wrUser1, wrUser4, wrSlave, wrBuf;
  assign wrBuf   = regWrEn &&  isBuf;
  assign wrCmd   = regWrEn && !isBuf && hit(regWord, OFF_CMD);
  assign wrAddr  = regWrEn && !isBuf && hit(regWord, OFF_ADDR);
  assign wrCtrl  = regWrEn && !isBuf && hit(regWord, OFF_CTRL);
  assign wrClock = regWrEn && !isBuf && hit(regWord, OFF_CLOCK);
  assign wrUser  = regWrEn && !isBuf && hit(regWord, OFF_USER);
  assign wrUser1 = regWrEn && !isBuf && hit(regWord, OFF_USER1);
  assign wrUser4 = regWrEn && !isBuf && hit(regWord, OFF_USER4);
  assign wrSlave = regWrEn && !isBuf && hit(regWord, OFF_SLAVE);

  // Register storage; self-acting bits are kept at zero in storage.
  logic [31:0] cmdR, addrR, ctrlR, clockR, userR, user1R, user4R, slaveR;
  logic        doneR, mosiR;

  localparam logic [31:0] CMD_KEEP   = ~(32'd1 << BIT_START);
  localparam logic [31:0] SLAVE_KEEP = ~((32'd1 << BIT_SRST) | (32'd1 << BIT_DONE));

  assign softRst  = wrSlave && regWrData[BIT_SRST];
  assign startReq = wrCmd && regWrData[BIT_START] && !busy && userR[BIT_DOUT]
                    && !slaveR[BIT_MODE] && !ctrlR[BIT_MMIO];
  assign holdCs   = user4R[BIT_HOLDCS];
  assign lastPos  = user1R[BIT_LEN_LSB +: POS_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdR   <= '0;
      addrR  <= '0;
      ctrlR  <= '0;
      clockR <= '0;
      userR  <= '0;
      user1R <= '0;
      user4R <= '0;
      slaveR <= '0;
    end else begin
      if (wrCmd)   cmdR   <= regWrData & CMD_KEEP;
      if (wrAddr)  addrR  <= regWrData;
      if (wrCtrl)  ctrlR  <= regWrData;
      if (wrClock) clockR <= regWrData;
      if (wrUser)  userR  <= regWrData;
      if (wrUser1) user1R <= regWrData;
      if (wrUser4) user4R <= regWrData;
      if (wrSlave) slaveR <= regWrData & SLAVE_KEEP;
    end
  end

  // Data buffer: byte-wide storage, four lanes per word.
  logic [7:0] bufMem [BUF_BYTES];

  always_ff @(posedge clk) begin
    if (wrBuf) begin
      for (int l = 0; l < 4; l++) begin
        bufMem[{bufWord, 2'(l)}] <= regWrData[8*l +: 8];
      end
    end
    if (strb.sampleBit && userR[BIT_RXCAP]) begin
      bufMem[bitPos[POS_W-1:3]][3'd7 - bitPos[2:0]] <= spiMiso;
    end
  end

  // Serial output bit and sticky done flag.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mosiR <= 1'b0;
      doneR <= 1'b0;
    end else if (strb.abort) begin
      mosiR <= 1'b0;
      doneR <= 1'b0;
    end else begin
      if (strb.loadBit) mosiR <= bufMem[bitPos[POS_W-1:3]][3'd7 - bitPos[2:0]];
      if (strb.doneSet)                        doneR <= 1'b1;
      else if (wrSlave && !regWrData[BIT_DONE]) doneR <= 1'b0;
    end
  end

  assign spiMosi    = mosiR;
  assign doneFlag   = doneR;
  assign mmioReadEn = ctrlR[BIT_MMIO];

  // Read path.
  logic [31:0] bufRdWord;
  for (genvar g = 0; g < 4; g++) begin : g_lane
    assign bufRdWord[8*g +: 8] = bufMem[{bufWord, 2'(g)}];
  end

  always_comb begin
    regRdData = '0;
    if (isBuf)                          regRdData = bufRdWord;
    else if (hit(regWord, OFF_CMD))     regRdData = cmdR | (32'(busy) << BIT_START);
    else if (hit(regWord, OFF_ADDR))    regRdData = addrR;
    else if (hit(regWord, OFF_CTRL))    regRdData = ctrlR;
    else if (hit(regWord, OFF_CLOCK))   regRdData = clockR;
    else if (hit(regWord, OFF_USER))    regRdData = userR;
    else if (hit(regWord, OFF_USER1))   regRdData = user1R;
    else if (hit(regWord, OFF_USER4))   regRdData = user4R;
    else if (hit(regWord, OFF_SLAVE))   regRdData = slaveR | (32'(doneR) << BIT_DONE);
  end

endmodule

// File: rtl/sfe_control.sv
module sfe_control
  import sfe_pkg::*;
#(
  parameter int BUF_BYTES = 64,
  localparam int POS_W = $clog2(BUF_BYTES * 8)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic             softRst,
  input  logic             holdCs,
  input  logic [POS_W-1:0] lastPos,
  input  logic             sckRiseStb,
  input  logic             sckFallStb,
  output logic             spiSck,
  output logic             spiCsN,
  output logic             busy,
  output sfeStrobe_t       strb,
  output logic [POS_W-1:0] bitPos
);

  sfeState_t        state;
  logic [POS_W-1:0] posR, lastR;
  logic             sckR, csNR;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      sckR  <= 1'b0;
      csNR  <= 1'b1;
      posR  <= '0;
      lastR <= '0;
    end else if (softRst) begin
      state <= ST_IDLE;
      sckR  <= 1'b0;
      csNR  <= 1'b1;
      posR  <= '0;
    end else begin
      case (state)
        ST_IDLE: if (startReq) begin
          state <= ST_WAIT_RISE;
          csNR  <= 1'b0;
          posR  <= '0;
          lastR <= lastPos;
        end
        ST_WAIT_RISE: if (sckRiseStb) begin
          sckR  <= 1'b1;
          state <= (posR == lastR) ? ST_WRAP : ST_WAIT_FALL;
        end
        ST_WAIT_FALL: if (sckFallStb) begin
          sckR  <= 1'b0;
          posR  <= posR + 1'b1;
          state <= ST_WAIT_RISE;
        end
        ST_WRAP: begin
          sckR  <= 1'b0;
          csNR  <= ~holdCs;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb       = '0;
    strb.abort = softRst;
    bitPos     = posR;
    if (!softRst) begin
      case (state)
        ST_IDLE: if (startReq) begin
          strb.loadBit = 1'b1;
          bitPos       = '0;
        end
        ST_WAIT_RISE: strb.sampleBit = sckRiseStb;
        ST_WAIT_FALL: if (sckFallStb) begin
          strb.loadBit = 1'b1;
          bitPos       = posR + 1'b1;
        end
        ST_WRAP: strb.doneSet = 1'b1;
        default: ;
      endcase
    end
  end

  assign spiSck = sckR;
  assign spiCsN = csNR;
  assign busy   = (state != ST_IDLE);

endmodule

// File: rtl/sfe_engine.sv
module sfe_engine
  import sfe_pkg::*;
#(
  parameter int BUF_BYTES = 64,
  localparam int ADDR_W = $clog2(BUF_BYTES) + 1,
  localparam int POS_W  = $clog2(BUF_BYTES * 8)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  logic              sckRiseStb,
  input  logic              sckFallStb,
  output logic              spiSck,
  output logic              spiCsN,
  output logic              spiMosi,
  input  logic              spiMiso,
  output logic              mmioReadEn
);

  sfeStrobe_t       strb;
  logic [POS_W-1:0] bitPos, lastPos;
  logic             busy, startReq, softRst, holdCs, doneFlag;

  sfe_datapath #(.BUF_BYTES(BUF_BYTES)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .busy      (busy),
    .strb      (strb),
    .bitPos    (bitPos),
    .spiMiso   (spiMiso),
    .spiMosi   (spiMosi),
    .startReq  (startReq),
    .softRst   (softRst),
    .holdCs    (holdCs),
    .lastPos   (lastPos),
    .doneFlag  (doneFlag),
    .mmioReadEn(mmioReadEn)
  );

  sfe_control #(.BUF_BYTES(BUF_BYTES)) ctl_i (
    .clk       (clk),
    .rstN      (rstN),
    .startReq  (startReq),
    .softRst   (softRst),
    .holdCs    (holdCs),
    .lastPos   (lastPos),
    .sckRiseStb(sckRiseStb),
    .sckFallStb(sckFallStb),
    .spiSck    (spiSck),
    .spiCsN    (spiCsN),
    .busy      (busy),
    .strb      (strb),
    .bitPos    (bitPos)
  );

endmodule

// File: rtl/sfe_checker.sv
module sfe_checker #(
  parameter int ADDR_W = 7
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic              busy,
  input logic              doneFlag,
  input logic              spiSck,
  input logic              spiCsN,
  input logic              spiMosi
);

  localparam logic [ADDR_W-1:0] SLAVE_ADDR = ADDR_W'(8'h30);

  // R6: serial clock rests low whenever no burst is running
  a_r6_sck_idle_low: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !spiSck);

  // R6: output bit holds while the serial clock stays high
  a_r6_mosi_stable_high: assert property (@(posedge clk) disable iff (!rstN)
    ($past(spiSck) && spiSck) |-> $stable(spiMosi));

  // R9: chip select is asserted through every busy cycle
  a_r9_cs_low_busy: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !spiCsN);

  // R8: done only rises as a burst ends
  a_r8_done_at_end: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneFlag) |-> ($past(busy) && !busy));

  // R8/R11: done only falls after a write to the slave word
  a_r8_done_clear_by_write: assert property (@(posedge clk) disable iff (!rstN)
    $fell(doneFlag) |-> $past(regWrEn && regAddr == SLAVE_ADDR));

endmodule

bind sfe_engine sfe_checker #(.ADDR_W(ADDR_W)) chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .regWrEn (regWrEn),
  .regAddr (regAddr),
  .busy    (busy),
  .doneFlag(doneFlag),
  .spiSck  (spiSck),
  .spiCsN  (spiCsN),
  .spiMosi (spiMosi)
);

// File: tb/sfe_engine_tb.sv
module sfe_engine_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [6:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        sckRiseStb = 1'b0;
  logic        sckFallStb = 1'b0;
  logic        spiSck, spiCsN, spiMosi, mmioReadEn;
  logic        spiMiso = 1'b0;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  logic [7:0] mdl [64];

  always #5 clk = ~clk;

  sfe_engine dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .sckRiseStb(sckRiseStb),
    .sckFallStb(sckFallStb), .spiSck(spiSck), .spiCsN(spiCsN),
    .spiMosi(spiMosi), .spiMiso(spiMiso), .mmioReadEn(mmioReadEn)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic pulse_rise();
    sckRiseStb = 1'b1; @(negedge clk); sckRiseStb = 1'b0;
  endtask

  task automatic pulse_fall();
    sckFallStb = 1'b1; @(negedge clk); sckFallStb = 1'b0;
  endtask

  task automatic check_buffer(input string req);
    logic [31:0] d;
    for (int w = 0; w < 16; w++) begin
      rd(7'h40 + 7'(4 * w), d);
      chk(req, $sformatf("buffer word %0d", w), d, {mdl[4*w+3], mdl[4*w+2], mdl[4*w+1], mdl[4*w]});
    end
  endtask

  // One burst: length, capture, hold, input pattern, optional mid-burst start poke.
  task automatic run_burst(input int nbits, input bit cap, input bit hold,
                           input logic [31:0] rxSeed, input int pokeAt);
    logic [31:0] d;
    wr(7'h2C, 32'(hold) << 30);
    wr(7'h1C, 32'h0800_0000 | 32'(cap));
    wr(7'h20, 32'(nbits - 1) << 17);
    wr(7'h30, 32'h0);
    wr(7'h00, 32'h0004_0000);
    chk("R9", "cs after start", 32'(spiCsN), 32'd0);
    rd(7'h00, d);
    chk("R12", "busy bit after start", 32'(d[18]), 32'd1);
    for (int b = 0; b < nbits; b++) begin
      if (b == pokeAt) begin
        wr(7'h00, 32'h0004_0000); // R10: ignored while busy
      end
      chk("R3/R6", $sformatf("mosi bit %0d", b), 32'(spiMosi), 32'(mdl[b/8][7 - b%8]));
      spiMiso = rxSeed[b % 32];
      pulse_rise();
      chk("R6", "sck high after rise", 32'(spiSck), 32'd1);
      if (cap) mdl[b/8][7 - b%8] = rxSeed[b % 32];
      if (b != nbits - 1) begin
        pulse_fall();
        chk("R6", "sck low after fall", 32'(spiSck), 32'd0);
      end
    end
    rd(7'h30, d);
    chk("R8", "done not yet one edge after last rise", 32'(d[4]), 32'd0);
    @(negedge clk);
    rd(7'h30, d);
    chk("R8", "done set two edges after last rise", 32'(d[4]), 32'd1);
    chk("R8", "sck low at end", 32'(spiSck), 32'd0);
    chk("R9", "cs at end vs hold", 32'(spiCsN), 32'(!hold));
    rd(7'h00, d);
    chk("R12", "busy clear at end", 32'(d[18]), 32'd0);
    if (pokeAt >= 0) chk("R10", "burst length kept despite restart", 32'(d[18]), 32'd0);
    repeat (3) @(negedge clk);
    rd(7'h30, d);
    chk("R8", "done stays set", 32'(d[4]), 32'd1);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    for (int a = 0; a < 64; a += 4) begin
      rd(7'(a), d);
      chk("R1", $sformatf("reg %02h after reset", a), d, 32'h0);
    end
    chk("R1", "cs", 32'(spiCsN), 32'd1);
    chk("R1", "sck", 32'(spiSck), 32'd0);
    chk("R1", "mosi", 32'(spiMosi), 32'd0);
    chk("R1", "mmio", 32'(mmioReadEn), 32'd0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    wr(7'h00, 32'h0000_1234); rd(7'h00, d); chk("R2", "command", d, 32'h0000_1234);
    chk("R2", "command without start leaves cs", 32'(spiCsN), 32'd1);
    wr(7'h00, 32'h0);
    wr(7'h04, 32'hDEAD_BEEF); rd(7'h04, d); chk("R2", "address", d, 32'hDEAD_BEEF);
    wr(7'h18, 32'h0001_2345); rd(7'h18, d); chk("R2", "clock", d, 32'h0001_2345);
    wr(7'h1C, 32'hF000_0004); rd(7'h1C, d); chk("R2", "user", d, 32'hF000_0004);
    wr(7'h20, 32'h0234_5678); rd(7'h20, d); chk("R2", "user1", d, 32'h0234_5678);
    wr(7'h2C, 32'h1357_9BDF); rd(7'h2C, d); chk("R2", "user4", d, 32'h1357_9BDF);
    wr(7'h30, 32'h4000_0015); rd(7'h30, d); chk("R8", "slave done not set by write", d, 32'h4000_0005);
    wr(7'h30, 32'h0);
    wr(7'h08, 32'h0002_0000); rd(7'h08, d); chk("R2", "control", d, 32'h0002_0000);
    chk("R2", "mmio output", 32'(mmioReadEn), 32'd1);
    wr(7'h08, 32'h0);
    chk("R2", "mmio output cleared", 32'(mmioReadEn), 32'd0);
    wr(7'h10, 32'hFFFF_FFFF); rd(7'h10, d); chk("R2", "unmapped 0x10", d, 32'h0);
    wr(7'h3C, 32'hFFFF_FFFF); rd(7'h3C, d); chk("R2", "unmapped 0x3C", d, 32'h0);
  endtask

  task automatic t_buffer();
    for (int w = 0; w < 16; w++) begin
      logic [31:0] v;
      v = 32'h1F2E_3D4C ^ (32'h0907_0503 * 32'(w + 1));
      wr(7'h40 + 7'(4 * w), v);
      for (int l = 0; l < 4; l++) mdl[4*w + l] = v[8*l +: 8];
    end
    check_buffer("R3");
  endtask

  task automatic t_blocked();
    logic [31:0] d;
    wr(7'h20, 32'(7) << 17);
    wr(7'h1C, 32'h0);
    wr(7'h00, 32'h0004_0000);
    repeat (2) @(negedge clk);
    chk("R4", "no start with data-out off", 32'(spiCsN), 32'd1);
    wr(7'h1C, 32'h0800_0000);
    wr(7'h30, 32'h4000_0000);
    wr(7'h00, 32'h0004_0000);
    repeat (2) @(negedge clk);
    chk("R4", "no start in slave mode", 32'(spiCsN), 32'd1);
    wr(7'h30, 32'h0);
    wr(7'h08, 32'h0002_0000);
    wr(7'h00, 32'h0004_0000);
    repeat (2) @(negedge clk);
    chk("R4", "no start with mmio on", 32'(spiCsN), 32'd1);
    rd(7'h00, d);
    chk("R4", "not busy", 32'(d[18]), 32'd0);
    pulse_rise();
    chk("R6", "rise strobe ignored when idle", 32'(spiSck), 32'd0);
    rd(7'h30, d);
    chk("R4", "done not set", 32'(d[4]), 32'd0);
    wr(7'h08, 32'h0);
  endtask

  task automatic t_done_clear();
    logic [31:0] d;
    wr(7'h30, 32'h10); rd(7'h30, d); chk("R8", "write 1 keeps done", 32'(d[4]), 32'd1);
    wr(7'h30, 32'h0);  rd(7'h30, d); chk("R8", "write 0 clears done", 32'(d[4]), 32'd0);
    wr(7'h30, 32'h10); rd(7'h30, d); chk("R8", "write 1 does not set", 32'(d[4]), 32'd0);
  endtask

  task automatic t_soft_reset();
    logic [31:0] d;
    wr(7'h2C, 32'h4000_0000);
    wr(7'h1C, 32'h0800_0000);
    wr(7'h20, 32'(15) << 17);
    wr(7'h30, 32'h0);
    wr(7'h00, 32'h0004_0000);
    pulse_rise(); pulse_fall(); pulse_rise();
    chk("R11", "sck high before abort", 32'(spiSck), 32'd1);
    wr(7'h30, 32'h8000_0000);
    chk("R11", "cs released by abort", 32'(spiCsN), 32'd1);
    chk("R11", "sck low after abort", 32'(spiSck), 32'd0);
    chk("R11", "mosi low after abort", 32'(spiMosi), 32'd0);
    rd(7'h00, d); chk("R11", "idle after abort", 32'(d[18]), 32'd0);
    rd(7'h30, d); chk("R11", "slave reads 0", d, 32'h0);
    rd(7'h20, d); chk("R11", "user1 kept", d, 32'(15) << 17);
    pulse_fall(); pulse_rise();
    chk("R6", "strobes ignored after abort", 32'(spiSck), 32'd0);
    repeat (3) @(negedge clk);
    rd(7'h30, d); chk("R11", "no done after abort", 32'(d[4]), 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_buffer();
    run_burst(32, 1'b0, 1'b0, 32'h0, -1);      // R5 aligned, no capture
    check_buffer("R7 capture off");
    run_burst(11, 1'b1, 1'b0, 32'h5A3C_96F1, -1); // R5 ragged, R7 capture
    check_buffer("R7 capture on");
    run_burst(8, 1'b0, 1'b1, 32'h0, -1);        // R9 hold
    chk("R9", "cs held between bursts", 32'(spiCsN), 32'd0);
    run_burst(16, 1'b1, 1'b0, 32'hC3A5_0F96, 5); // R9 release, R10 restart ignored
    check_buffer("R7 second capture");
    t_done_clear();
    t_blocked();
    t_soft_reset();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule